// File: doc/BRIEF.md
# Non-Volatile Row-Buffer Address Assembler

This block sits behind the command decoder of a low-power DDR-style memory interface whose device is non-volatile. An array row address reaches it in two pieces. A preactive command delivers the high-order bits A20 to A32. A later activate command delivers A5 to A19. The bank bits of the activate then name one of 4 or 8 row data buffers, and the complete aligned row address is parked in that buffer. Any address may be placed in any buffer, so the bank bits select a buffer and are never part of the address. Each activate also issues a one-cycle array-fetch request that carries the buffer index and the aligned byte address of the row.

A read names a buffer and a column (C1 to C11, with C0 always zero). The block merges the buffer's stored row with the column bits that fall inside one row and returns the resulting byte address into the array. The row-buffer size is a power-of-two parameter between 32 and 4096 bytes. It sets which activate bits are dropped: those below the row size. It also sets which read column bits are dropped: those at or above the row size. Write and refresh commands do not apply to this device type and raise error pulses. A read of a buffer that holds no row also raises an error pulse.

Top module: `nvrb_rowbuf_asm`

## Requirements
- R1: After reset all outputs are low and every buffer is empty, so a read of any buffer gives an unloaded-read error.
- R2: A preactive stores `pre_hi` (bit 0 is A20, bit 12 is A32) for its buffer. One cycle after an activate, `fetch_vld` pulses with `fetch_bank` set to the buffer index and `fetch_addr` set to {stored high bits, `act_lo`, 5'b0} (`act_lo` bit 0 is A5). The same address becomes that buffer's row.
- R3: An activate with no preactive before it reuses the high bits last captured for that buffer (zero after reset). A preactive to one buffer leaves the high bits of every other buffer unchanged.
- R4: Activate address bits below log2(ROW_BYTES) are ignored: they read as zero in `fetch_addr` and in the stored row.
- R5: One cycle after a read of a loaded buffer, `rd_out_vld` pulses. `rd_byte_addr` carries the stored row bits at and above log2(ROW_BYTES) and the column {`rd_col`, 1'b0} bits below it. Column bits at or above the row size are ignored.
- R6: The buffer index is the low log2(NUM_BUFS) bits of the bank field. With 4 buffers the top bank bit is ignored. `fetch_bank` is the index, zero-extended.
- R7: One cycle after a read of a buffer that holds no row, `err_unloaded` pulses and `rd_out_vld` stays low.
- R8: One cycle after a write strobe, `err_write` pulses. No buffer content changes.
- R9: One cycle after a refresh strobe, `err_refresh` pulses. No buffer content changes.
- R10: Every output pulse lasts one cycle and appears only after its own command. An idle cycle produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pre_vld | input | 1 | Preactive command strobe |
| pre_bank | input | 3 | Bank field of the preactive |
| pre_hi | input | 13 | Address bits A20..A32 |
| act_vld | input | 1 | Activate command strobe |
| act_bank | input | 3 | Bank field of the activate |
| act_lo | input | 15 | Address bits A5..A19 |
| rd_vld | input | 1 | Read command strobe |
| rd_bank | input | 3 | Bank field of the read |
| rd_col | input | 11 | Column bits C1..C11 |
| wr_vld | input | 1 | Write command strobe (illegal) |
| ref_vld | input | 1 | Refresh command strobe (illegal) |
| fetch_vld | output | 1 | Array-fetch request pulse |
| fetch_bank | output | 3 | Buffer index receiving the row |
| fetch_addr | output | 33 | Aligned byte address of the row |
| rd_out_vld | output | 1 | Read address valid pulse |
| rd_byte_addr | output | 33 | Resolved byte address of the read |
| err_write | output | 1 | Write-not-supported error pulse |
| err_refresh | output | 1 | Illegal-refresh error pulse |
| err_unloaded | output | 1 | Read of an empty buffer error pulse |

## Verification
The assertions assume that the upstream decoder raises at most one command strobe per cycle. Under that assumption no activate shares a cycle with a preactive or a read, and the block never has to rank two strobes against each other. The bench keeps to this rule by driving exactly one command kind per cycle, chosen at random with weights, with idle cycles mixed in. The bench drives two instances in parallel from the same stimulus, one with 8 buffers and 512-byte rows and one with 4 buffers and 32-byte rows. Both instances see every command, so the ignored-bit rules are exercised at two row sizes and two buffer counts.

// File: rtl/nvrb_pkg.sv
package nvrb_pkg;
    localparam int BA_W   = 3;
    localparam int HI_W   = 13;
    localparam int LO_W   = 15;
    localparam int LO_LSB = 5;
    localparam int ADDR_W = LO_LSB + LO_W + HI_W;
    localparam int COL_W  = 12;

    typedef logic [ADDR_W-1:0] addr_t;

    // registered response of the block
    typedef struct packed {
        logic            fetch_vld;
        logic [BA_W-1:0] fetch_bank;
        addr_t           fetch_addr;
        logic            rd_vld;
        addr_t           rd_addr;
        logic            err_wr;
        logic            err_ref;
        logic            err_unl;
    } resp_t;

    // one buffer slot
    typedef struct packed {
        logic  loaded;
        addr_t row;
    } slot_t;
endpackage

// File: rtl/nvrb_bank_sel.sv
module nvrb_bank_sel
    import nvrb_pkg::*;
#(
    parameter int NUM_BUFS = 8,
    parameter int IDX_W    = 3
) (
    input  logic [BA_W-1:0]  bank,
    output logic [IDX_W-1:0] idx
);
    assign idx = bank[IDX_W-1:0];

    generate
        if (IDX_W < BA_W) begin : g_drop
            // upper bank bits do not select anything with fewer buffers
            logic unused_bank_hi;
            assign unused_bank_hi = ^bank[BA_W-1:IDX_W];
        end
    endgenerate
endmodule

// File: rtl/nvrb_hi_store.sv
module nvrb_hi_store
    import nvrb_pkg::*;
#(
    parameter int NUM_BUFS = 8,
    parameter int IDX_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [IDX_W-1:0] cap_idx,
    input  logic [HI_W-1:0]  cap_hi,
    input  logic [IDX_W-1:0] look_idx,
    output logic [HI_W-1:0]  look_hi
);
    logic [HI_W-1:0] hi_all [NUM_BUFS];

    generate
        for (genvar g = 0; g < NUM_BUFS; g++) begin : g_slot
            logic [HI_W-1:0] hi_d, hi_q;

            always_comb begin
                hi_d = hi_q;
                if (cap_en && (cap_idx == IDX_W'(g))) begin
                    hi_d = cap_hi;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) hi_q <= '0;
                else        hi_q <= hi_d;
            end

            assign hi_all[g] = hi_q;
        end
    endgenerate

    assign look_hi = hi_all[look_idx];
endmodule

// File: rtl/nvrb_row_store.sv
module nvrb_row_store
    import nvrb_pkg::*;
#(
    parameter int NUM_BUFS = 8,
    parameter int IDX_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_idx,
    input  addr_t            ld_row,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_loaded,
    output addr_t            rd_row
);
    slot_t slot_all [NUM_BUFS];

    generate
        for (genvar g = 0; g < NUM_BUFS; g++) begin : g_slot
            slot_t slot_d, slot_q;

            always_comb begin
                slot_d = slot_q;
                if (ld_en && (ld_idx == IDX_W'(g))) begin
                    slot_d.loaded = 1'b1;
                    slot_d.row    = ld_row;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) slot_q <= '0;
                else        slot_q <= slot_d;
            end

            assign slot_all[g] = slot_q;
        end
    endgenerate

    assign rd_loaded = slot_all[rd_idx].loaded;
    assign rd_row    = slot_all[rd_idx].row;
endmodule

// File: rtl/nvrb_rd_resolve.sv
module nvrb_rd_resolve
    import nvrb_pkg::*;
#(
    parameter int ROW_BYTES = 512
) (
    input  addr_t              row,
    input  logic [COL_W-1:1]   col,
    output addr_t              byte_addr
);
    localparam addr_t OFS_MASK = addr_t'(ROW_BYTES - 1);

    addr_t col_full;

    always_comb begin
        col_full  = addr_t'({col, 1'b0});
        byte_addr = (row & ~OFS_MASK) | (col_full & OFS_MASK);
    end
endmodule

// File: rtl/nvrb_rowbuf_asm.sv
module nvrb_rowbuf_asm
    import nvrb_pkg::*;
#(
    parameter int NUM_BUFS  = 8,
    parameter int ROW_BYTES = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pre_vld,
    input  logic [2:0]        pre_bank,
    input  logic [12:0]       pre_hi,
    input  logic              act_vld,
    input  logic [2:0]        act_bank,
    input  logic [14:0]       act_lo,
    input  logic              rd_vld,
    input  logic [2:0]        rd_bank,
    input  logic [10:0]       rd_col,
    input  logic              wr_vld,
    input  logic              ref_vld,
    output logic              fetch_vld,
    output logic [2:0]        fetch_bank,
    output logic [32:0]       fetch_addr,
    output logic              rd_out_vld,
    output logic [32:0]       rd_byte_addr,
    output logic              err_write,
    output logic              err_refresh,
    output logic              err_unloaded
);
    localparam int    IDX_W    = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1;
    localparam addr_t OFS_MASK = addr_t'(ROW_BYTES - 1);

    logic [IDX_W-1:0] pre_idx, act_idx, rd_idx;
    logic [HI_W-1:0]  act_hi;
    addr_t            act_row;
    logic             slot_loaded;
    addr_t            slot_row;
    addr_t            rd_resolved;
    resp_t            resp_d, resp_q;

    nvrb_bank_sel #(.NUM_BUFS(NUM_BUFS), .IDX_W(IDX_W)) u_sel_pre (
        .bank (pre_bank),
        .idx  (pre_idx)
    );
    nvrb_bank_sel #(.NUM_BUFS(NUM_BUFS), .IDX_W(IDX_W)) u_sel_act (
        .bank (act_bank),
        .idx  (act_idx)
    );
    nvrb_bank_sel #(.NUM_BUFS(NUM_BUFS), .IDX_W(IDX_W)) u_sel_rd (
        .bank (rd_bank),
        .idx  (rd_idx)
    );

    nvrb_hi_store #(.NUM_BUFS(NUM_BUFS), .IDX_W(IDX_W)) u_hi (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (pre_vld),
        .cap_idx  (pre_idx),
        .cap_hi   (pre_hi),
        .look_idx (act_idx),
        .look_hi  (act_hi)
    );

    // full row address, low bits inside one row forced to zero
    assign act_row = {act_hi, act_lo, {LO_LSB{1'b0}}} & ~OFS_MASK;

    nvrb_row_store #(.NUM_BUFS(NUM_BUFS), .IDX_W(IDX_W)) u_rows (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_en     (act_vld),
        .ld_idx    (act_idx),
        .ld_row    (act_row),
        .rd_idx    (rd_idx),
        .rd_loaded (slot_loaded),
        .rd_row    (slot_row)
    );

    nvrb_rd_resolve #(.ROW_BYTES(ROW_BYTES)) u_res (
        .row       (slot_row),
        .col       (rd_col),
        .byte_addr (rd_resolved)
    );

    always_comb begin
        resp_d            = '0;
        resp_d.fetch_vld  = act_vld;
        resp_d.fetch_bank = act_vld ? BA_W'(act_idx) : '0;
        resp_d.fetch_addr = act_vld ? act_row : '0;
        resp_d.rd_vld     = rd_vld && slot_loaded;
        resp_d.rd_addr    = (rd_vld && slot_loaded) ? rd_resolved : '0;
        resp_d.err_unl    = rd_vld && !slot_loaded;
        resp_d.err_wr     = wr_vld;
        resp_d.err_ref    = ref_vld;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) resp_q <= '0;
        else        resp_q <= resp_d;
    end

    assign fetch_vld    = resp_q.fetch_vld;
    assign fetch_bank   = resp_q.fetch_bank;
    assign fetch_addr   = resp_q.fetch_addr;
    assign rd_out_vld   = resp_q.rd_vld;
    assign rd_byte_addr = resp_q.rd_addr;
    assign err_write    = resp_q.err_wr;
    assign err_refresh  = resp_q.err_ref;
    assign err_unloaded = resp_q.err_unl;
endmodule

// File: rtl/nvrb_rowbuf_chk.sv
module nvrb_rowbuf_chk #(
    parameter int NUM_BUFS  = 8,
    parameter int ROW_BYTES = 512
) (
    input logic        clk,
    input logic        rst_n,
    input logic        pre_vld,
    input logic        act_vld,
    input logic [2:0]  act_bank,
    input logic        rd_vld,
    input logic [10:0] rd_col,
    input logic        wr_vld,
    input logic        ref_vld,
    input logic        fetch_vld,
    input logic [2:0]  fetch_bank,
    input logic [32:0] fetch_addr,
    input logic        rd_out_vld,
    input logic [32:0] rd_byte_addr,
    input logic        err_write,
    input logic        err_refresh,
    input logic        err_unloaded
);
    localparam logic [32:0] OFS  = 33'(ROW_BYTES - 1);
    localparam logic [2:0]  IMSK = 3'(NUM_BUFS - 1);

    AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({pre_vld, act_vld, rd_vld, wr_vld, ref_vld}) <= 1); // R10
    AST_FETCH_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        act_vld |=> fetch_vld); // R2
    AST_FETCH_BANK_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        act_vld |=> fetch_bank == ($past(act_bank) & IMSK)); // R6
    AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_vld |-> (fetch_addr & OFS) == '0); // R4
    AST_RD_COL_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |=> (!rd_out_vld || ((rd_byte_addr & OFS) == (33'({$past(rd_col), 1'b0}) & OFS)))); // R5
    AST_RD_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |=> (rd_out_vld != err_unloaded)); // R7
    AST_WR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_vld |=> err_write && !fetch_vld && !rd_out_vld); // R8
    AST_REF_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        ref_vld |=> err_refresh && !fetch_vld && !rd_out_vld); // R9
    AST_NO_STRAY_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        !act_vld |=> !fetch_vld); // R10
    AST_NO_STRAY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_vld |=> !rd_out_vld && !err_unloaded); // R10
endmodule

bind nvrb_rowbuf_asm nvrb_rowbuf_chk #(.NUM_BUFS(NUM_BUFS), .ROW_BYTES(ROW_BYTES)) u_chk (.*);

// File: tb/tb_nvrb_rowbuf_asm.sv
`timescale 1ns/1ps
module tb_nvrb_rowbuf_asm;
    localparam int K_IDLE = 0, K_PRE = 1, K_ACT = 2, K_RD = 3, K_WR = 4, K_REF = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        pre_vld = 0, act_vld = 0, rd_vld = 0, wr_vld = 0, ref_vld = 0;
    logic [2:0]  pre_bank = 0, act_bank = 0, rd_bank = 0;
    logic [12:0] pre_hi = 0;
    logic [14:0] act_lo = 0;
    logic [10:0] rd_col = 0;

    logic [1:0]  fv, rv, ew, er, eu;
    logic [2:0]  fb [2];
    logic [32:0] fa [2];
    logic [32:0] ra [2];

    nvrb_rowbuf_asm #(.NUM_BUFS(8), .ROW_BYTES(512)) dut (
        .clk(clk), .rst_n(rst_n),
        .pre_vld(pre_vld), .pre_bank(pre_bank), .pre_hi(pre_hi),
        .act_vld(act_vld), .act_bank(act_bank), .act_lo(act_lo),
        .rd_vld(rd_vld), .rd_bank(rd_bank), .rd_col(rd_col),
        .wr_vld(wr_vld), .ref_vld(ref_vld),
        .fetch_vld(fv[0]), .fetch_bank(fb[0]), .fetch_addr(fa[0]),
        .rd_out_vld(rv[0]), .rd_byte_addr(ra[0]),
        .err_write(ew[0]), .err_refresh(er[0]), .err_unloaded(eu[0])
    );

    nvrb_rowbuf_asm #(.NUM_BUFS(4), .ROW_BYTES(32)) dut_s (
        .clk(clk), .rst_n(rst_n),
        .pre_vld(pre_vld), .pre_bank(pre_bank), .pre_hi(pre_hi),
        .act_vld(act_vld), .act_bank(act_bank), .act_lo(act_lo),
        .rd_vld(rd_vld), .rd_bank(rd_bank), .rd_col(rd_col),
        .wr_vld(wr_vld), .ref_vld(ref_vld),
        .fetch_vld(fv[1]), .fetch_bank(fb[1]), .fetch_addr(fa[1]),
        .rd_out_vld(rv[1]), .rd_byte_addr(ra[1]),
        .err_write(ew[1]), .err_refresh(er[1]), .err_unloaded(eu[1])
    );

    int checks = 0;
    int failures = 0;

    // reference state, per instance and buffer
    logic [12:0] m_hi  [2][8];
    logic [32:0] m_row [2][8];
    logic        m_val [2][8];

    function automatic int nbufs(int i);
        return (i == 0) ? 8 : 4;
    endfunction

    function automatic logic [32:0] ofs_mask(int i);
        return (i == 0) ? 33'd511 : 33'd31;
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 2; i++)
            for (int b = 0; b < 8; b++) begin
                m_hi[i][b] = '0; m_row[i][b] = '0; m_val[i][b] = 1'b0;
            end
    endtask

    // one command, response checked one clock later
    task automatic issue(int kind, logic [2:0] bank, logic [12:0] hi, logic [14:0] lo,
                         logic [10:0] col, string tag);
        logic [4:0]  e_flags [2];
        logic [2:0]  e_fb [2];
        logic [32:0] e_fa [2];
        logic [32:0] e_ra [2];
        pre_vld = (kind == K_PRE); act_vld = (kind == K_ACT); rd_vld = (kind == K_RD);
        wr_vld = (kind == K_WR); ref_vld = (kind == K_REF);
        pre_bank = bank; act_bank = bank; rd_bank = bank;
        pre_hi = hi; act_lo = lo; rd_col = col;
        for (int i = 0; i < 2; i++) begin
            int idx;
            logic [32:0] m;
            idx = int'(bank) & (nbufs(i) - 1);
            m = ofs_mask(i);
            e_flags[i] = '0; e_fb[i] = '0; e_fa[i] = '0; e_ra[i] = '0;
            case (kind)
                K_PRE: m_hi[i][idx] = hi;
                K_ACT: begin
                    e_flags[i][4] = 1'b1;
                    e_fb[i] = 3'(idx);
                    e_fa[i] = {m_hi[i][idx], lo, 5'b0} & ~m;
                    m_row[i][idx] = e_fa[i];
                    m_val[i][idx] = 1'b1;
                end
                K_RD: begin
                    if (m_val[i][idx]) begin
                        e_flags[i][3] = 1'b1;
                        e_ra[i] = (m_row[i][idx] & ~m) | (33'({col, 1'b0}) & m);
                    end else begin
                        e_flags[i][0] = 1'b1;
                    end
                end
                K_WR:  e_flags[i][2] = 1'b1;
                K_REF: e_flags[i][1] = 1'b1;
                default: ;
            endcase
        end
        @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            logic [4:0] got;
            got = {fv[i], rv[i], ew[i], er[i], eu[i]};
            chk(got == e_flags[i], tag, $sformatf("inst%0d pulses{fetch,rd,wr,ref,unl}", i),
                64'(got), 64'(e_flags[i]));
            if (e_flags[i][4]) begin
                chk(fa[i] == e_fa[i], tag, $sformatf("inst%0d fetch_addr", i), 64'(fa[i]), 64'(e_fa[i]));
                chk(fb[i] == e_fb[i], tag, $sformatf("inst%0d fetch_bank", i), 64'(fb[i]), 64'(e_fb[i]));
            end
            if (e_flags[i][3])
                chk(ra[i] == e_ra[i], tag, $sformatf("inst%0d rd_byte_addr", i), 64'(ra[i]), 64'(e_ra[i]));
        end
        pre_vld = 0; act_vld = 0; rd_vld = 0; wr_vld = 0; ref_vld = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        model_reset();
        repeat (4) @(negedge clk);
        // R1: quiet outputs while and right after reset
        for (int i = 0; i < 2; i++)
            chk({fv[i], rv[i], ew[i], er[i], eu[i]} == 5'b0, "R1", "reset pulses", 64'({fv[i], rv[i], ew[i], er[i], eu[i]}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int b = 0; b < 8; b++) issue(K_RD, 3'(b), '0, '0, 11'h123, "R1");

        // R3: activate with no preactive uses zero high bits
        issue(K_ACT, 3'd1, '0, 15'h1234, '0, "R3");
        issue(K_RD, 3'd1, '0, '0, 11'h7ff, "R5");
        // R2: preactive then activate
        issue(K_PRE, 3'd2, 13'h1abc, '0, '0, "R2");
        issue(K_ACT, 3'd2, 13'h0000, 15'h7fff, '0, "R4");
        // R3: second activate reuses the same high bits, other buffers untouched
        issue(K_PRE, 3'd3, 13'h0f0f, '0, '0, "R3");
        issue(K_ACT, 3'd2, '0, 15'h0005, '0, "R3");
        issue(K_RD, 3'd2, '0, '0, 11'h555, "R5");
        // R6: bank 5 aliases buffer 1 when only 4 buffers exist
        issue(K_PRE, 3'd5, 13'h1fff, '0, '0, "R6");
        issue(K_ACT, 3'd5, '0, 15'h2aaa, '0, "R6");
        issue(K_RD, 3'd1, '0, '0, 11'h00f, "R6");
        issue(K_RD, 3'd5, '0, '0, 11'h3c1, "R6");
        // R8 / R9: illegal commands flag and leave buffers alone
        issue(K_WR, 3'd2, '0, '0, '0, "R8");
        issue(K_RD, 3'd2, '0, '0, 11'h001, "R8");
        issue(K_REF, 3'd1, '0, '0, '0, "R9");
        issue(K_RD, 3'd1, '0, '0, 11'h002, "R9");
        // R7: still-unloaded buffer in the large instance
        issue(K_RD, 3'd7, '0, '0, 11'h010, "R7");
        // R10: idle cycle, no pulse
        issue(K_IDLE, '0, '0, '0, '0, "R10");

        for (int n = 0; n < 1500; n++) begin
            int r, kind;
            string tag;
            r = int'($urandom_range(0, 99));
            if      (r < 20) kind = K_PRE;
            else if (r < 45) kind = K_ACT;
            else if (r < 80) kind = K_RD;
            else if (r < 86) kind = K_WR;
            else if (r < 92) kind = K_REF;
            else             kind = K_IDLE;
            case (kind)
                K_PRE:  tag = "R2";
                K_ACT:  tag = "R4";
                K_RD:   tag = "R5";
                K_WR:   tag = "R8";
                K_REF:  tag = "R9";
                default: tag = "R10";
            endcase
            issue(kind, 3'($urandom_range(0, 7)), 13'($urandom), 15'($urandom), 11'($urandom), tag);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule